// File: doc/BRIEF.md
# Dual-Rail NULL-Convention Gate with Hysteresis

This block models one two-input gate of a dual-rail, self-timed datapath. Each logical signal travels on a pair of rails: a spacer value with both rails low separates successive data words, and a data value raises exactly one rail to say TRUE or FALSE. The gate computes either AND or OR of its two inputs, chosen by a parameter. Unlike a plain Boolean gate, its output is stateful. It commits to a result only once every input has left the spacer. It returns to the spacer only after every input has returned there. In all other cases it keeps its last output.

The held output sits in a clocked register, so the gate can be dropped into a synchronous model of a self-timed pipeline. The output reacts one clock edge after the inputs that cause a change. An input pair carrying the forbidden both-rails-high code freezes the output and raises an error flag in the same cycle.

Top module: `ncl_th_gate`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its synchronised release, the output is NULL (2'b00), whatever the inputs carry.
- R2: Every rail pair uses bit 1 as the TRUE rail and bit 0 as the FALSE rail: 2'b00 is NULL, 2'b10 is TRUE, 2'b01 is FALSE and 2'b11 is illegal. The output never shows 2'b11.
- R3: With the output NULL and both inputs DATA, the output becomes, one clock edge later, the AND of the decoded inputs when FUNC is FN_AND.
- R4: With the output NULL and at least one input NULL, the output stays NULL.
- R5: With the output DATA and at least one input DATA, the output keeps its value, even if the DATA inputs change to other DATA values.
- R6: With the output DATA and both inputs NULL, the output becomes NULL one clock edge later.
- R7: When any input carries 2'b11, err is high in the same cycle and the output keeps its value across the next clock edge.
- R8: Each change of the output alters exactly one rail, so the output never steps directly between TRUE and FALSE.
- R9: When FUNC is FN_OR, the rule of R3 applies with the OR of the decoded inputs.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the held output |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| a_rail | input | 2 | First dual-rail operand, {true rail, false rail} |
| b_rail | input | 2 | Second dual-rail operand, {true rail, false rail} |
| y_rail | output | 2 | Held dual-rail result, {true rail, false rail} |
| err | output | 1 | High while any operand carries the illegal code |

## Verification
The bench builds two copies of the gate that share one pair of operands. The first copy uses FN_AND and the second uses FN_OR. Because both copies see the same stimulus, a single random sequence reaches the AND firing rule and the OR firing rule, with all of their FALSE and TRUE outcomes. The sequence also covers every NULL/DATA mix that must hold. Illegal codes can arrive while either copy is NULL or DATA, so the hold rule for the illegal code is exercised against both stored states.

// File: rtl/ncl_gate_pkg.sv
package ncl_gate_pkg;
  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_NULL = 2'b00;
  localparam rail_t RAIL_TRUE = 2'b10;
  localparam rail_t RAIL_FALSE = 2'b01;
  localparam rail_t RAIL_BAD = 2'b11;

  typedef enum logic {
    FN_AND = 1'b0,
    FN_OR  = 1'b1
  } gate_fn_e;
endpackage

// File: rtl/ncl_rst_sync.sv
module ncl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ncl_rail_decode.sv
module ncl_rail_decode
  import ncl_gate_pkg::*;
(
  input  rail_t rail,
  output logic  is_data,
  output logic  is_null,
  output logic  is_bad,
  output logic  value
);
  always_comb begin
    is_null = (rail == RAIL_NULL);
    is_bad  = (rail == RAIL_BAD);
    is_data = rail[1] ^ rail[0];
    value   = rail[1];
  end
endmodule

// File: rtl/ncl_hyst_core.sv
module ncl_hyst_core
  import ncl_gate_pkg::*;
#(
  parameter int       N_IN = 2,
  parameter gate_fn_e FUNC = FN_AND
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_data,
  input  logic [N_IN-1:0] in_null,
  input  logic [N_IN-1:0] in_bad,
  input  logic [N_IN-1:0] in_val,
  output rail_t           y
);
  rail_t y_q;
  rail_t y_nxt;
  logic  y_en;
  logic  all_data;
  logic  all_null;
  logic  any_bad;
  logic  fn_val;

  always_comb begin
    all_data = &in_data;
    all_null = &in_null;
    any_bad  = |in_bad;
    fn_val   = (FUNC == FN_OR) ? |in_val : &in_val;
    y_en     = 1'b0;
    y_nxt    = y_q;
    if (!any_bad) begin
      if ((y_q == RAIL_NULL) && all_data) begin
        y_en  = 1'b1;
        y_nxt = fn_val ? RAIL_TRUE : RAIL_FALSE;
      end else if ((y_q != RAIL_NULL) && all_null) begin
        y_en  = 1'b1;
        y_nxt = RAIL_NULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_q <= RAIL_NULL;
    else if (y_en) y_q <= y_nxt;
  end

  assign y = y_q;

  AST_NO_BAD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    y_q != RAIL_BAD); // R2
  AST_FIRE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(y_q) == RAIL_NULL && y_q != RAIL_NULL) |-> $past(&in_data)); // R3
  AST_MIXED_HOLDS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(y_q) == RAIL_NULL && !$past(&in_data)) |-> y_q == RAIL_NULL); // R4
  AST_DATA_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(y_q) != RAIL_NULL && y_q != RAIL_NULL) |-> y_q == $past(y_q)); // R5
  AST_RELEASE_NEEDS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(y_q) != RAIL_NULL && y_q == RAIL_NULL) |-> $past(&in_null)); // R6
  AST_BAD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|in_bad) |-> $stable(y_q)); // R7
  AST_ONE_RAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(y_q ^ $past(y_q)) <= 1); // R8
endmodule

// File: rtl/ncl_th_gate.sv
module ncl_th_gate
  import ncl_gate_pkg::*;
#(
  parameter gate_fn_e FUNC = FN_AND
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] a_rail,
  input  logic [1:0] b_rail,
  output logic [1:0] y_rail,
  output logic       err
);
  localparam int N_IN = 2;

  rail_t            ops [N_IN];
  logic [N_IN-1:0]  op_data;
  logic [N_IN-1:0]  op_null;
  logic [N_IN-1:0]  op_bad;
  logic [N_IN-1:0]  op_val;
  logic             rst_n_sync;
  rail_t            y_int;

  assign ops[0] = a_rail;
  assign ops[1] = b_rail;

  ncl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_dec
    ncl_rail_decode u_dec (
      .rail    (ops[i]),
      .is_data (op_data[i]),
      .is_null (op_null[i]),
      .is_bad  (op_bad[i]),
      .value   (op_val[i])
    );
  end

  ncl_hyst_core #(.N_IN(N_IN), .FUNC(FUNC)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .in_data (op_data),
    .in_null (op_null),
    .in_bad  (op_bad),
    .in_val  (op_val),
    .y       (y_int)
  );

  assign y_rail = y_int;
  assign err    = |op_bad;

  AST_ERR_MATCHES_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    err == ((a_rail == RAIL_BAD) || (b_rail == RAIL_BAD))); // R7
  AST_RESET_NULL: assert property (@(posedge clk)
    !rst_n_sync |=> y_rail == RAIL_NULL); // R1
endmodule

// File: tb/ncl_th_gate_test.sv
module ncl_th_gate_test;
  import ncl_gate_pkg::*;

  logic  clk = 1'b0;
  logic  rst_n;
  rail_t a, b;
  logic [1:0] y_and, y_or;
  logic  err_and, err_or;
  int    checks = 0;
  int    fails = 0;
  rail_t exp_and, exp_or;
  rail_t prev_and, prev_or;
  string req_and, req_or;

  always #5 clk = ~clk;

  ncl_th_gate #(.FUNC(FN_AND)) uut (
    .clk(clk), .rst_n(rst_n), .a_rail(a), .b_rail(b), .y_rail(y_and), .err(err_and));
  ncl_th_gate #(.FUNC(FN_OR)) uut_or (
    .clk(clk), .rst_n(rst_n), .a_rail(a), .b_rail(b), .y_rail(y_or), .err(err_or));

  function automatic bit is_dat(rail_t r);
    return (r == RAIL_TRUE) || (r == RAIL_FALSE);
  endfunction

  function automatic rail_t model(rail_t cur, rail_t x, rail_t z, bit use_or);
    bit v;
    if (x == RAIL_BAD || z == RAIL_BAD) return cur;
    if (cur == RAIL_NULL && is_dat(x) && is_dat(z)) begin
      v = use_or ? (x == RAIL_TRUE || z == RAIL_TRUE) : (x == RAIL_TRUE && z == RAIL_TRUE);
      return v ? RAIL_TRUE : RAIL_FALSE;
    end
    if (cur != RAIL_NULL && x == RAIL_NULL && z == RAIL_NULL) return RAIL_NULL;
    return cur;
  endfunction

  function automatic string classify(rail_t cur, rail_t x, rail_t z, bit use_or);
    if (x == RAIL_BAD || z == RAIL_BAD) return "R7";
    if (cur == RAIL_NULL && is_dat(x) && is_dat(z)) return use_or ? "R9" : "R3";
    if (cur == RAIL_NULL) return "R4";
    if (x == RAIL_NULL && z == RAIL_NULL) return "R6";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(rail_t na, rail_t nb);
    @(negedge clk);
    check(y_and == exp_and, req_and, "and output", y_and, exp_and);
    check(y_or == exp_or, req_or, "or output", y_or, exp_or);
    check(y_and != RAIL_BAD && y_or != RAIL_BAD, "R2", "illegal output", {y_and, y_or}, 0);
    check($countones(y_and ^ prev_and) <= 1 && $countones(y_or ^ prev_or) <= 1,
          "R8", "rails changed", {y_and ^ prev_and, y_or ^ prev_or}, 0);
    prev_and = y_and;
    prev_or  = y_or;
    a = na;
    b = nb;
    #1;
    check(err_and == (na == RAIL_BAD || nb == RAIL_BAD), "R7", "err and", err_and,
          int'(na == RAIL_BAD || nb == RAIL_BAD));
    check(err_or == err_and, "R7", "err or", err_or, err_and);
    req_and = classify(exp_and, na, nb, 1'b0);
    req_or  = classify(exp_or, na, nb, 1'b1);
    exp_and = model(exp_and, na, nb, 1'b0);
    exp_or  = model(exp_or, na, nb, 1'b1);
  endtask

  function automatic rail_t pick();
    int v = int'($urandom % 13);
    if (v < 6) return RAIL_NULL;
    if (v < 9) return RAIL_TRUE;
    if (v < 12) return RAIL_FALSE;
    return RAIL_BAD;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    a = RAIL_TRUE;
    b = RAIL_TRUE;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(y_and == RAIL_NULL && y_or == RAIL_NULL, "R1", "reset output",
            {y_and, y_or}, 0);
    end
    a = RAIL_NULL;
    b = RAIL_NULL;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_and = RAIL_NULL;
    exp_or = RAIL_NULL;
    prev_and = y_and;
    prev_or = y_or;
    req_and = "R1";
    req_or = "R1";
    // directed: every NULL/DATA mix, DATA swaps, illegal codes
    step(RAIL_TRUE, RAIL_NULL);
    step(RAIL_NULL, RAIL_FALSE);
    step(RAIL_TRUE, RAIL_FALSE);
    step(RAIL_FALSE, RAIL_TRUE);
    step(RAIL_NULL, RAIL_TRUE);
    step(RAIL_FALSE, RAIL_NULL);
    step(RAIL_NULL, RAIL_NULL);
    step(RAIL_TRUE, RAIL_TRUE);
    step(RAIL_NULL, RAIL_NULL);
    step(RAIL_FALSE, RAIL_FALSE);
    step(RAIL_BAD, RAIL_NULL);
    step(RAIL_NULL, RAIL_NULL);
    step(RAIL_BAD, RAIL_TRUE);
    step(RAIL_TRUE, RAIL_TRUE);
    step(RAIL_NULL, RAIL_BAD);
    step(RAIL_NULL, RAIL_NULL);
    for (int i = 0; i < 3000; i++) begin
      rail_t ra = pick();
      rail_t rb = pick();
      step(ra, rb);
    end
    step(RAIL_NULL, RAIL_NULL);
    step(RAIL_NULL, RAIL_NULL);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule